// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This controller gathers interrupt events from a set of peripheral sources and from four system-exception causes. Each event is latched in a pending register. Every peripheral source carries a two-bit priority field. The field either disables the source or places it in one of three levels. The controller picks one winning pending request and offers it to the CPU as a vector index, using a request/acknowledge handshake. When the CPU acknowledges, the serviced pending bit is cleared.

Software reaches the pending, enable and priority state through a small synchronous register bus. A write takes effect on a clock edge. A read is combinational on the address. Software can poll a pending bit and clear it by writing 0 to it, even while the source is kept from interrupting. Three of the four exception causes do not depend on the global enable and are served ahead of every peripheral source.

Top module: `tri_lvl_irq_ctrl`

## Requirements
- R1: A high bit on `irq_src[i]` at a clock edge sets pending bit i. Software reads the pending bits at bus address 0, with bit i standing for source i.
- R2: A write to address 0 clears every pending bit whose data bit is 0 and leaves every bit written 1 unchanged. A write to address 3 does the same for the exception pending bits.
- R3: When an event arrives in the same cycle as a clear of the same bit, the bit stays set afterwards. The clear may come from a software write or from an acknowledge.
- R4: Source i has a priority field at bits [2i+1:2i] of address 2. Value 0 keeps the source from interrupting, but its pending bit still latches and can be read. Values 1, 2 and 3 select Level 1, 2 and 3. A pending source at a higher level wins over any source at a lower level, whatever the source indices.
- R5: Among pending sources at the same level, the source with the lowest index wins.
- R6: Bit 0 of address 1 is the global enable. While it is 0, no peripheral source and no watchdog-interrupt exception raises `cpu_irq`. Their pending bits still latch.
- R7: The exception bits of `exc_evt` and of address 3 are: 0 illegal-instruction trap, 1 watchdog interrupt, 2 watchdog oscillator failure, 3 primary oscillator failure. Exceptions 0, 2 and 3 raise `cpu_irq` even when the global enable is 0. Exception k is presented as vector NSRC+k. Exceptions win over every peripheral source, and a lower k wins over a higher k.
- R8: When `cpu_irq` is low and a winner exists, `cpu_irq` rises at the next edge with the winner's index on `cpu_vec`. Both hold steady until an acknowledge.
- R9: `cpu_ack` while `cpu_irq` is high clears the pending bit named by `cpu_vec` and drops `cpu_irq` at that edge. The next winner is offered one edge later.
- R10: After reset, all pending bits, priority fields, the global enable and `cpu_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Peripheral interrupt events, sampled every edge |
| exc_evt | input | 4 | System exception events |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational on bus_addr |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | IDX_W | Index of the presented source or exception |
| cpu_ack | input | 1 | CPU acknowledge that it has vectored |

## Verification
Two functions can act on the same pending bit in one cycle. One is the latching of a new event. The other is a clear, from either a software write of 0 or the acknowledge of that very source. Directed cases drive the event together with the clearing write, and also together with `cpu_ack` while that source is being presented. The bench judges the outcome by reading the pending register and by watching the same vector appear again one cycle later. A randomized phase also makes these collisions happen, and a behavioural model checks every cycle's `cpu_irq`, `cpu_vec` and read data against its own result.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int NUM_EXC = 4;

   // exception cause positions (order is service priority)
   localparam int EXC_TRAP    = 0;
   localparam int EXC_WDT_IRQ = 1;
   localparam int EXC_WDT_OSC = 2;
   localparam int EXC_XTAL    = 3;

   // causes that the global enable can hold back
   localparam logic [NUM_EXC-1:0] EXC_GATED = 4'b0010;

   // register map
   localparam int REG_PEND = 0;
   localparam int REG_GEN  = 1;
   localparam int REG_PRIO = 2;
   localparam int REG_EXC  = 3;

   typedef enum logic [1:0] {
      LVL_OFF = 2'd0,
      LVL_1   = 2'd1,
      LVL_2   = 2'd2,
      LVL_3   = 2'd3
   } irq_lvl_e;

endpackage

// File: rtl/irqc_req_bank.sv
module irqc_req_bank #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] sw_clr,
   input  logic [W-1:0] ack_clr,
   output logic [W-1:0] pend
);

   if (W < 1) begin : g_chk_w
      $error("irqc_req_bank: W must be at least 1");
   end

   logic [W-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~(sw_clr | ack_clr)) | evt;
   end

   assign pend = pend_q;

   assert_event_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((pend & $past(evt)) == $past(evt)));

   assert_set_beats_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & (sw_clr | ack_clr))) |=> ((pend & $past(evt & (sw_clr | ack_clr))) != '0));

   assert_sw_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sw_clr & ~evt)) |=> ((pend & $past(sw_clr & ~evt)) == '0));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs import irqc_pkg::*; #(
   parameter int NSRC   = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic [NSRC-1:0]      src_pend,
   input  logic [NUM_EXC-1:0]   exc_pend,
   output logic                 gen_en,
   output logic [NSRC-1:0][1:0] src_prio,
   output logic [NSRC-1:0]      src_sw_clr,
   output logic [NUM_EXC-1:0]   exc_sw_clr,
   output logic [DATA_W-1:0]    bus_rdata
);

   localparam int PRIO_W = 2 * NSRC;

   if (PRIO_W > DATA_W) begin : g_chk_prio
      $error("irqc_regs: priority fields do not fit the data width");
   end
   if (ADDR_W < 2) begin : g_chk_addr
      $error("irqc_regs: address width must reach four registers");
   end

   logic              gen_q;
   logic [PRIO_W-1:0] prio_q;

   wire hit_pend = (bus_addr == ADDR_W'(REG_PEND));
   wire hit_gen  = (bus_addr == ADDR_W'(REG_GEN));
   wire hit_prio = (bus_addr == ADDR_W'(REG_PRIO));
   wire hit_exc  = (bus_addr == ADDR_W'(REG_EXC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q  <= 1'b0;
         prio_q <= '0;
      end else if (bus_we) begin
         if (hit_gen)  gen_q  <= bus_wdata[0];
         if (hit_prio) prio_q <= bus_wdata[PRIO_W-1:0];
      end
   end

   assign gen_en     = gen_q;
   assign src_prio   = prio_q;
   assign src_sw_clr = (bus_we && hit_pend) ? ~bus_wdata[NSRC-1:0]    : '0;
   assign exc_sw_clr = (bus_we && hit_exc)  ? ~bus_wdata[NUM_EXC-1:0] : '0;

   always_comb begin
      bus_rdata = '0;
      if (hit_pend)      bus_rdata[NSRC-1:0]    = src_pend;
      else if (hit_gen)  bus_rdata[0]           = gen_q;
      else if (hit_prio) bus_rdata[PRIO_W-1:0]  = prio_q;
      else if (hit_exc)  bus_rdata[NUM_EXC-1:0] = exc_pend;
   end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter import irqc_pkg::*; #(
   parameter int NSRC  = 16,
   parameter int IDX_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSRC-1:0]      src_pend,
   input  logic [NSRC-1:0][1:0] src_prio,
   input  logic                 gen_en,
   input  logic [NUM_EXC-1:0]   exc_pend,
   output logic                 win_valid,
   output logic                 win_is_exc,
   output logic [IDX_W-1:0]     win_idx
);

   localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (NSRC < 2) begin : g_chk_n
      $error("irqc_arbiter: NSRC must be at least 2");
   end
   if ((1 << IDX_W) < NSRC + NUM_EXC) begin : g_chk_idx
      $error("irqc_arbiter: IDX_W too narrow for all vectors");
   end

   // per-level hit vectors, level 0 never wins
   logic [3:0][NSRC-1:0] lvl_hit;
   assign lvl_hit[0] = '0;

   for (genvar lv = 1; lv < 4; lv++) begin : g_lvl
      logic             any_l;
      logic [IDX_W-1:0] idx_l;
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         assign lvl_hit[lv][s] = src_pend[s] & gen_en & (src_prio[s] == 2'(lv));
      end
      assign any_l = |lvl_hit[lv];
      always_comb begin
         idx_l = '0;
         for (int i = NSRC - 1; i >= 0; i--)
            if (lvl_hit[lv][i]) idx_l = IDX_W'(i);
      end
   end

   logic [NUM_EXC-1:0] exc_ok;
   logic [IDX_W-1:0]   exc_idx;

   assign exc_ok = exc_pend & (~EXC_GATED | {NUM_EXC{gen_en}});

   always_comb begin
      exc_idx = '0;
      for (int k = NUM_EXC - 1; k >= 0; k--)
         if (exc_ok[k]) exc_idx = IDX_W'(k);
   end

   always_comb begin
      win_valid  = 1'b1;
      win_is_exc = 1'b0;
      win_idx    = '0;
      if (|exc_ok) begin
         win_is_exc = 1'b1;
         win_idx    = IDX_W'(NSRC) + exc_idx;
      end else if (g_lvl[3].any_l) begin
         win_idx = g_lvl[3].idx_l;
      end else if (g_lvl[2].any_l) begin
         win_idx = g_lvl[2].idx_l;
      end else if (g_lvl[1].any_l) begin
         win_idx = g_lvl[1].idx_l;
      end else begin
         win_valid = 1'b0;
      end
   end

   // assertion helpers
   logic [SRC_W-1:0] src_sel;
   logic [NSRC-1:0]  below_mask;
   logic [1:0]       sel_lvl;
   assign src_sel    = win_idx[SRC_W-1:0];
   assign below_mask = (NSRC'(1) << src_sel) - NSRC'(1);
   assign sel_lvl    = src_prio[src_sel];

   assert_level_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_is_exc) |->
         (src_pend[src_sel] && sel_lvl != LVL_OFF &&
          (sel_lvl == LVL_3 || lvl_hit[3] == '0) &&
          (sel_lvl >= LVL_2 || lvl_hit[2] == '0)));

   assert_low_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_is_exc) |-> ((lvl_hit[sel_lvl] & below_mask) == '0));

   assert_exc_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(exc_pend & ~EXC_GATED)) |-> (win_valid && win_is_exc));

endmodule

// File: rtl/irqc_present.sv
module irqc_present #(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_valid,
   input  logic [IDX_W-1:0] win_idx,
   input  logic             cpu_ack,
   output logic             cpu_irq,
   output logic [IDX_W-1:0] cpu_vec,
   output logic             ack_fire
);

   logic             irq_q;
   logic [IDX_W-1:0] vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         vec_q <= '0;
      end else if (irq_q) begin
         if (cpu_ack) irq_q <= 1'b0;
      end else if (win_valid) begin
         irq_q <= 1'b1;
         vec_q <= win_idx;
      end
   end

   assign cpu_irq  = irq_q;
   assign cpu_vec  = vec_q;
   assign ack_fire = irq_q & cpu_ack;

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && !cpu_ack) |=> (cpu_irq && $stable(cpu_vec)));

   assert_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_irq && win_valid) |=> cpu_irq);

   assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && cpu_ack) |=> !cpu_irq);

endmodule

// File: rtl/tri_lvl_irq_ctrl.sv
module tri_lvl_irq_ctrl import irqc_pkg::*; #(
   parameter int NSRC   = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2,
   parameter int IDX_W  = $clog2(NSRC + NUM_EXC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSRC-1:0]      irq_src,
   input  logic [NUM_EXC-1:0]   exc_evt,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 cpu_irq,
   output logic [IDX_W-1:0]     cpu_vec,
   input  logic                 cpu_ack
);

   logic [NSRC-1:0]      src_pend, src_sw_clr, src_ack_clr;
   logic [NUM_EXC-1:0]   exc_pend, exc_sw_clr, exc_ack_clr;
   logic [NSRC-1:0][1:0] src_prio;
   logic                 gen_en, ack_fire;
   logic                 win_valid, win_is_exc;
   logic [IDX_W-1:0]     win_idx;
   logic                 unused_win_is_exc;

   assign unused_win_is_exc = win_is_exc;

   // acknowledge decode back to one pending bit
   for (genvar s = 0; s < NSRC; s++) begin : g_src_ack
      assign src_ack_clr[s] = ack_fire && (cpu_vec == IDX_W'(s));
   end
   for (genvar e = 0; e < NUM_EXC; e++) begin : g_exc_ack
      assign exc_ack_clr[e] = ack_fire && (cpu_vec == IDX_W'(NSRC + e));
   end

   irqc_req_bank #(.W(NSRC)) u_src_bank (
      .clk(clk), .rst_n(rst_n), .evt(irq_src),
      .sw_clr(src_sw_clr), .ack_clr(src_ack_clr), .pend(src_pend));

   irqc_req_bank #(.W(NUM_EXC)) u_exc_bank (
      .clk(clk), .rst_n(rst_n), .evt(exc_evt),
      .sw_clr(exc_sw_clr), .ack_clr(exc_ack_clr), .pend(exc_pend));

   irqc_regs #(.NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .src_pend(src_pend), .exc_pend(exc_pend),
      .gen_en(gen_en), .src_prio(src_prio), .src_sw_clr(src_sw_clr),
      .exc_sw_clr(exc_sw_clr), .bus_rdata(bus_rdata));

   irqc_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_prio(src_prio),
      .gen_en(gen_en), .exc_pend(exc_pend), .win_valid(win_valid),
      .win_is_exc(win_is_exc), .win_idx(win_idx));

   irqc_present #(.IDX_W(IDX_W)) u_pres (
      .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx),
      .cpu_ack(cpu_ack), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec),
      .ack_fire(ack_fire));

   assert_gen_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_irq && !gen_en && ((exc_pend & ~EXC_GATED) == '0)) |=> !cpu_irq);

   assert_nmi_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_irq && ((exc_pend & ~EXC_GATED) != '0)) |=>
         (cpu_irq && cpu_vec >= IDX_W'(NSRC)));

endmodule

// File: tb/tri_lvl_irq_ctrl_bench.sv
module tri_lvl_irq_ctrl_bench;

   // delays in 1 ps units: 5000 ps period gives 200 MHz
   localparam int HALF = 2500;
   localparam int NS   = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_src = '0;
   logic [3:0]  exc_evt = '0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cpu_irq;
   logic [4:0]  cpu_vec;
   logic        cpu_ack = 1'b0;

   int n_chk = 0, n_fail = 0, cycles = 0;
   bit done = 0;

   always #HALF clk = ~clk;

   tri_lvl_irq_ctrl u_tri_lvl_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .exc_evt(exc_evt),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec),
      .cpu_ack(cpu_ack));

   // ---------------- behavioural reference ----------------
   bit [15:0] m_pend;
   bit [3:0]  m_exc;
   bit        m_gen, m_irq;
   int        m_prio [NS];
   int        m_vec;

   function automatic int m_pick();
      for (int k = 0; k < 4; k++)
         if (m_exc[k] && (k != 1 || m_gen)) return NS + k;
      if (m_gen)
         for (int lv = 3; lv >= 1; lv--)
            for (int s = 0; s < NS; s++)
               if (m_pend[s] && m_prio[s] == lv) return s;
      return -1;
   endfunction

   function automatic logic [31:0] m_read(input logic [1:0] a);
      logic [31:0] r = '0;
      case (a)
         2'd0: r[15:0] = m_pend;
         2'd1: r[0] = m_gen;
         2'd2: for (int s = 0; s < NS; s++) r[2*s +: 2] = 2'(m_prio[s]);
         default: r[3:0] = m_exc;
      endcase
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin : ref_model
      int w;
      bit fire, clr;
      bit [15:0] np;
      bit [3:0] ne;
      if (!rst_n) begin
         m_pend = '0; m_exc = '0; m_gen = 0; m_irq = 0; m_vec = 0;
         for (int s = 0; s < NS; s++) m_prio[s] = 0;
      end else begin
         fire = m_irq && cpu_ack;
         w = m_pick();
         for (int s = 0; s < NS; s++) begin
            clr = (bus_we && bus_addr == 2'd0 && !bus_wdata[s]) || (fire && m_vec == s);
            np[s] = (m_pend[s] && !clr) || irq_src[s];
         end
         for (int k = 0; k < 4; k++) begin
            clr = (bus_we && bus_addr == 2'd3 && !bus_wdata[k]) || (fire && m_vec == NS + k);
            ne[k] = (m_exc[k] && !clr) || exc_evt[k];
         end
         if (bus_we && bus_addr == 2'd1) m_gen = bus_wdata[0];
         if (bus_we && bus_addr == 2'd2)
            for (int s = 0; s < NS; s++) m_prio[s] = int'(bus_wdata[2*s +: 2]);
         if (fire) m_irq = 0;
         else if (!m_irq && w >= 0) begin m_irq = 1; m_vec = w; end
         m_pend = np;
         m_exc = ne;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 cpu_irq vs model", 32'(cpu_irq), 32'(m_irq));
         if (m_irq) chk("R4 R5 R7 cpu_vec vs model", 32'(cpu_vec), 32'(m_vec));
         chk("R1 R2 bus_rdata vs model", bus_rdata, m_read(bus_addr));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #500;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      cyc(1);
      bus_we = 0; bus_wdata = '0;
   endtask

   task automatic peek(input string tag, input logic [1:0] a, input logic [31:0] exp);
      bus_addr = a;
      #100;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic pulse_src(input logic [15:0] v);
      irq_src = v; cyc(1); irq_src = '0;
   endtask

   task automatic pulse_exc(input logic [3:0] v);
      exc_evt = v; cyc(1); exc_evt = '0;
   endtask

   task automatic ack();
      cpu_ack = 1; cyc(1); cpu_ack = 0;
   endtask

   // ---------------- scenarios ----------------
   initial begin
      cyc(3);
      chk("R10 irq after reset", 32'(cpu_irq), 0);
      rst_n = 1;
      cyc(1);
      peek("R10 pending after reset", 2'd0, 0);
      peek("R10 prio after reset", 2'd2, 0);
      peek("R10 enable after reset", 2'd1, 0);

      // basic path, all sources Level 1
      wr(2'd2, 32'h5555_5555);
      wr(2'd1, 32'h1);
      pulse_src(16'h0020);
      peek("R1 pending bit 5", 2'd0, 32'h20);
      chk("R8 irq not yet", 32'(cpu_irq), 0);
      cyc(1);
      chk("R8 irq raised", 32'(cpu_irq), 1);
      chk("R8 vector 5", 32'(cpu_vec), 5);
      cyc(3);
      chk("R8 irq held", 32'(cpu_irq), 1);
      chk("R8 vector held", 32'(cpu_vec), 5);
      ack();
      chk("R9 irq dropped", 32'(cpu_irq), 0);
      peek("R9 pending cleared", 2'd0, 0);

      // level order: src3 L1, src9 L3, src12 L2
      wr(2'd2, 32'h020C_0040);
      pulse_src(16'h1208);
      cyc(1);
      chk("R4 level 3 first", 32'(cpu_vec), 9);
      ack(); cyc(1);
      chk("R4 level 2 next", 32'(cpu_vec), 12);
      ack(); cyc(1);
      chk("R4 level 1 last", 32'(cpu_vec), 3);
      ack();

      // tie within Level 2
      wr(2'd2, 32'hAAAA_AAAA);
      pulse_src(16'h0084);
      cyc(1);
      chk("R5 lower index wins", 32'(cpu_vec), 2);
      ack(); cyc(1);
      chk("R5 then higher index", 32'(cpu_vec), 7);
      ack();

      // disabled field: latched, pollable, not presented
      wr(2'd2, 32'hAAAA_A8AA);
      pulse_src(16'h0010);
      cyc(3);
      chk("R4 field 0 gives no irq", 32'(cpu_irq), 0);
      peek("R4 field 0 still pending", 2'd0, 32'h10);
      wr(2'd0, 32'hFFFF_FFEF);
      peek("R2 write 0 clears", 2'd0, 0);

      // global enable off
      wr(2'd1, 32'h0);
      wr(2'd2, 32'h5555_5555);
      pulse_src(16'h0042);
      cyc(2);
      chk("R6 no irq with enable off", 32'(cpu_irq), 0);
      peek("R6 still latched", 2'd0, 32'h42);
      wr(2'd0, 32'hFFFF_FFBF);
      peek("R2 write 1 keeps other bit", 2'd0, 32'h02);
      pulse_exc(4'b0010);
      cyc(2);
      chk("R6 watchdog irq held back", 32'(cpu_irq), 0);
      peek("R6 watchdog irq latched", 2'd3, 32'h2);
      pulse_exc(4'b1000);
      cyc(1);
      chk("R7 osc failure bypasses enable", 32'(cpu_irq), 1);
      chk("R7 vector NSRC+3", 32'(cpu_vec), 19);
      ack(); cyc(1);
      chk("R6 nothing eligible after ack", 32'(cpu_irq), 0);
      wr(2'd1, 32'h1);
      cyc(1);
      chk("R7 exception before source", 32'(cpu_vec), 17);
      ack(); cyc(1);
      chk("R7 source after exception", 32'(cpu_vec), 1);
      ack();
      peek("R9 exceptions cleared", 2'd3, 0);

      // set wins over software clear
      wr(2'd1, 32'h0);
      pulse_src(16'h0001);
      peek("R1 bit 0 latched", 2'd0, 32'h1);
      irq_src = 16'h0001;
      wr(2'd0, 32'h0);
      irq_src = '0;
      peek("R3 set beats write clear", 2'd0, 32'h1);
      wr(2'd0, 32'h0);
      peek("R2 plain clear", 2'd0, 0);

      // set wins over acknowledge clear
      wr(2'd2, 32'h3);
      wr(2'd1, 32'h1);
      pulse_src(16'h0001);
      cyc(1);
      chk("R8 vector 0", 32'(cpu_vec), 0);
      irq_src = 16'h0001;
      ack();
      irq_src = '0;
      chk("R9 irq dropped on ack", 32'(cpu_irq), 0);
      peek("R3 set beats ack clear", 2'd0, 32'h1);
      cyc(1);
      chk("R3 re-presented", 32'(cpu_irq), 1);
      chk("R3 same vector", 32'(cpu_vec), 0);
      ack();

      // randomized traffic compared each cycle against the model
      for (int i = 0; i < 3000; i++) begin
         irq_src = ($urandom % 6 == 0) ? 16'(1 << ($urandom % 16)) : '0;
         if ($urandom % 20 == 0) irq_src = irq_src | 16'($urandom);
         exc_evt = ($urandom % 40 == 0) ? 4'(1 << ($urandom % 4)) : '0;
         cpu_ack = cpu_irq && ($urandom % 3 == 0);
         bus_we = ($urandom % 8 == 0);
         bus_addr = 2'($urandom % 4);
         bus_wdata = $urandom | $urandom;
         if (bus_addr == 2'd1) bus_wdata[0] = ($urandom % 4 != 0);
         cyc(1);
      end
      irq_src = '0; exc_evt = '0; cpu_ack = 0; bus_we = 0;
      cyc(2);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule